// File: doc/BRIEF.md
# Byte/Word Data Bus Configurator

This block sits between the pins of an external flash-style parallel bus and an internal array port that is always 16 bits wide. A mode input chooses between 16-bit word transfers and 8-bit byte transfers. In byte mode the top data pin stops carrying data. It becomes the least-significant address bit and picks which half of the addressed array word a transfer uses.

Every bus cycle is sampled on the clock and sorted into one of four kinds: idle, read, data write or command write. A read drives the selected byte or the full word back out and enables exactly the pins that carry read data. A data write goes to the array with byte enables, so the array can merge a single byte into a stored word. A command write is always 8 bits wide: only the low byte is passed on, and nothing is written to the array.

Top module: `bwc_bus_cfg`

## Requirements
- R1: While reset is asserted, and after it is released until a new bus cycle is registered, `dq_oe` is all zeros and `arr_wr` and `cmd_valid` are 0.
- R2: A read in word mode (`ce`=1, `oe`=1, `we`=0, `word_mode`=1) sets `dq_oe` to 16'hFFFF one clock later, and `dq_out` equals the full `arr_rdata`.
- R3: A read in byte mode takes the lane from `dq_in[15]` at the sampling edge. Lane 0 places `arr_rdata[7:0]` on `dq_out[7:0]` and lane 1 places `arr_rdata[15:8]` there. `dq_out[15:8]` is zero, and `dq_in[14:8]` has no effect.
- R4: A read in byte mode sets `dq_oe` to 16'h00FF one clock later. Pins 8 to 14 stay tri-stated and pin 15 stays an input.
- R5: A data write in word mode (`ce`=1, `we`=1, `cmd`=0) gives `arr_wr`=1, `arr_be`=2'b11 and `arr_wdata`=`dq_in` one clock later, and `dq_oe` is zero even if `oe` is high.
- R6: A data write in byte mode gives `arr_wr`=1 and `arr_wdata` = the low byte of `dq_in` repeated in both halves. `arr_be` is 2'b01 when `dq_in[15]`=0 and 2'b10 when it is 1.
- R7: A command write (`ce`=1, `we`=1, `cmd`=1) gives `cmd_valid`=1 and `cmd_data`=`dq_in[7:0]` one clock later in either mode. `dq_in[15:8]` is ignored and `arr_wr` stays 0.
- R8: When `ce`=0, or when `oe`=0 with no write, `dq_oe` is zero one clock later. With `ce`=0, writes and commands have no effect.
- R9: `arr_addr` equals `addr` as it was at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| word_mode | input | 1 | 1 = 16-bit word mode, 0 = 8-bit byte mode |
| ce | input | 1 | Chip selected, active high |
| oe | input | 1 | Output enable request, active high |
| we | input | 1 | Write strobe, active high |
| cmd | input | 1 | Marks a write as a command cycle |
| addr | input | 20 | Word address from the pins |
| dq_in | input | 16 | Values on the data pins; bit 15 is the lane address in byte mode |
| dq_out | output | 16 | Read data to drive onto the pins |
| dq_oe | output | 16 | Per-pin output enable |
| arr_addr | output | 20 | Word address to the array |
| arr_rdata | input | 16 | Array read data for `arr_addr` |
| arr_wr | output | 1 | Array write strobe |
| arr_be | output | 2 | Array byte enables (bit 1 = upper byte) |
| arr_wdata | output | 16 | Array write data |
| cmd_valid | output | 1 | A command byte was captured |
| cmd_data | output | 8 | Captured command byte |

## Verification
The bench reads the same byte-mode address in both lanes. A design that swapped the lanes, or used the wrong pin as the lane bit, would return the other half of the word. It also drives junk on pins 8 to 14 and on the upper byte of command cycles. A design that leaked those bits would show them in `dq_out` or `cmd_data`. Writes with `oe` held high and cycles without `ce` would expose a design that drives the bus during a write, or that reacts while the chip is not selected. A reset applied during a write would expose a design that leaves a stale write strobe asserted.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE,
        CYC_READ,
        CYC_WRITE,
        CYC_CMD
    } cyc_e;

    // Decode one sampled bus cycle; a write has priority over a read.
    function automatic cyc_e classify(input logic ce, input logic oe,
                                      input logic we, input logic cmd);
        if (!ce)
            return CYC_IDLE;
        else if (we)
            return cmd ? CYC_CMD : CYC_WRITE;
        else if (oe)
            return CYC_READ;
        else
            return CYC_IDLE;
    endfunction

endpackage

// File: rtl/bwc_read_lane.sv
module bwc_read_lane #(
    parameter int DW = 16
) (
    input  logic          word_mode,
    input  logic          lane,
    input  logic [DW-1:0] rd_word,
    output logic [DW-1:0] pin_val
);
    localparam int HB = DW / 2;

    for (genvar i = 0; i < HB; i++) begin : g_bit
        assign pin_val[i]      = (word_mode || !lane) ? rd_word[i] : rd_word[HB+i];
        assign pin_val[HB + i] = word_mode ? rd_word[HB+i] : 1'b0;
    end
endmodule

// File: rtl/bwc_write_steer.sv
module bwc_write_steer #(
    parameter int DW = 16
) (
    input  logic          word_mode,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] wdata,
    output logic [1:0]    be
);
    localparam int HB = DW / 2;

    logic lane;
    assign lane  = dq_in[DW-1];
    assign wdata = word_mode ? dq_in : {dq_in[HB-1:0], dq_in[HB-1:0]};
    assign be    = word_mode ? 2'b11 : (lane ? 2'b10 : 2'b01);
endmodule

// File: rtl/bwc_bus_cfg.sv
module bwc_bus_cfg
    import bwc_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_mode,
    input  logic          ce,
    input  logic          oe,
    input  logic          we,
    input  logic          cmd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] dq_oe,
    output logic [AW-1:0] arr_addr,
    input  logic [DW-1:0] arr_rdata,
    output logic          arr_wr,
    output logic [1:0]    arr_be,
    output logic [DW-1:0] arr_wdata,
    output logic          cmd_valid,
    output logic [DW/2-1:0] cmd_data
);
    localparam int HB = DW / 2;
    localparam logic [DW-1:0] BYTE_OE = {{HB{1'b0}}, {HB{1'b1}}};

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          lane;
        logic          mode;
        logic [DW-1:0] drive;
        logic          wr;
        logic [1:0]    be;
        logic [DW-1:0] wdata;
        logic          cmdv;
        logic [HB-1:0] cmdd;
    } state_t;

    state_t s_d, s_q;
    cyc_e   kind;
    logic [DW-1:0] steer_wdata;
    logic [1:0]    steer_be;

    bwc_write_steer #(.DW(DW)) u_steer (
        .word_mode (word_mode),
        .dq_in     (dq_in),
        .wdata     (steer_wdata),
        .be        (steer_be)
    );

    always_comb begin
        kind        = classify(ce, oe, we, cmd);
        s_d         = s_q;
        s_d.addr    = addr;
        s_d.lane    = dq_in[DW-1] & ~word_mode;
        s_d.mode    = word_mode;
        s_d.drive   = '0;
        s_d.wr      = 1'b0;
        s_d.cmdv    = 1'b0;
        case (kind)
            CYC_READ:  s_d.drive = word_mode ? '1 : BYTE_OE;
            CYC_WRITE: begin
                s_d.wr    = 1'b1;
                s_d.be    = steer_be;
                s_d.wdata = steer_wdata;
            end
            CYC_CMD: begin
                s_d.cmdv = 1'b1;
                s_d.cmdd = dq_in[HB-1:0];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    bwc_read_lane #(.DW(DW)) u_lane (
        .word_mode (s_q.mode),
        .lane      (s_q.lane),
        .rd_word   (arr_rdata),
        .pin_val   (dq_out)
    );

    assign dq_oe     = s_q.drive;
    assign arr_addr  = s_q.addr;
    assign arr_wr    = s_q.wr;
    assign arr_be    = s_q.be;
    assign arr_wdata = s_q.wdata;
    assign cmd_valid = s_q.cmdv;
    assign cmd_data  = s_q.cmdd;

    a_r2_word_full_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && oe && !we && word_mode) |=> (dq_oe == {DW{1'b1}}));

    a_r4_byte_low_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && oe && !we && !word_mode) |=> (dq_oe == BYTE_OE));

    a_r6_byte_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && we && !cmd && !word_mode) |=>
            ($countones(arr_be) == 1 && arr_be[1] == $past(dq_in[DW-1])));

    a_r7_cmd_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !arr_wr);

    a_r8_idle_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce && oe) |=> (dq_oe == '0));

    a_r9_addr_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (arr_addr == $past(addr)));

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!arr_wr && !cmd_valid && dq_oe == '0));
endmodule

// File: tb/tb_bwc_bus_cfg.sv
module tb_bwc_bus_cfg;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int NV = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic word_mode = 1'b1, ce = 1'b0, oe = 1'b0, we = 1'b0, cmd = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out, dq_oe, arr_rdata, arr_wdata;
    logic [AW-1:0] arr_addr;
    logic arr_wr, cmd_valid;
    logic [1:0] arr_be;
    logic [7:0] cmd_data;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Array model: contents derived from the word address.
    assign arr_rdata = arr_addr[15:0] ^ 16'hA5C3;

    bwc_bus_cfg #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .ce(ce), .oe(oe),
        .we(we), .cmd(cmd), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .arr_wr(arr_wr), .arr_be(arr_be), .arr_wdata(arr_wdata),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        mode, sel, oen, wen, cmdn;
        logic [19:0] a;
        logic [15:0] dq;
        logic [15:0] e_oe, e_out;
        logic        e_wr;
        logic [1:0]  e_be;
        logic [15:0] e_wd;
        logic        e_cmdv;
        logic [7:0]  e_cmdd;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        // R2 word reads
        '{4'd2, 1'b1,1'b1,1'b1,1'b0,1'b0, 20'h00012, 16'h0000, 16'hFFFF, 16'hA5D1, 1'b0, 2'b00, 16'h0000, 1'b0, 8'h00},
        '{4'd2, 1'b1,1'b1,1'b1,1'b0,1'b0, 20'h0ABCD, 16'h0000, 16'hFFFF, 16'h0E0E, 1'b0, 2'b00, 16'h0000, 1'b0, 8'h00},
        // R3 byte reads, both lanes of one word
        '{4'd3, 1'b0,1'b1,1'b1,1'b0,1'b0, 20'h00034, 16'h0000, 16'h00FF, 16'h00F7, 1'b0, 2'b00, 16'h0000, 1'b0, 8'h00},
        '{4'd3, 1'b0,1'b1,1'b1,1'b0,1'b0, 20'h00034, 16'h8000, 16'h00FF, 16'h00A5, 1'b0, 2'b00, 16'h0000, 1'b0, 8'h00},
        // R4 byte read with junk on pins 8..14
        '{4'd4, 1'b0,1'b1,1'b1,1'b0,1'b0, 20'h00100, 16'hFF00, 16'h00FF, 16'h00A4, 1'b0, 2'b00, 16'h0000, 1'b0, 8'h00},
        // R8 not selected / output disabled
        '{4'd8, 1'b1,1'b0,1'b1,1'b0,1'b0, 20'h00012, 16'h0000, 16'h0000, 16'h0000, 1'b0, 2'b00, 16'h0000, 1'b0, 8'h00},
        '{4'd8, 1'b1,1'b1,1'b0,1'b0,1'b0, 20'h00012, 16'h0000, 16'h0000, 16'h0000, 1'b0, 2'b00, 16'h0000, 1'b0, 8'h00},
        // R5 word write
        '{4'd5, 1'b1,1'b1,1'b0,1'b1,1'b0, 20'h00200, 16'h1234, 16'h0000, 16'h0000, 1'b1, 2'b11, 16'h1234, 1'b0, 8'h00},
        // R6 byte writes, low then high lane
        '{4'd6, 1'b0,1'b1,1'b0,1'b1,1'b0, 20'h00201, 16'h7F5A, 16'h0000, 16'h0000, 1'b1, 2'b01, 16'h5A5A, 1'b0, 8'h00},
        '{4'd6, 1'b0,1'b1,1'b0,1'b1,1'b0, 20'h00202, 16'h80C3, 16'h0000, 16'h0000, 1'b1, 2'b10, 16'hC3C3, 1'b0, 8'h00},
        // R7 commands in word and byte mode, upper byte junk
        '{4'd7, 1'b1,1'b1,1'b0,1'b1,1'b1, 20'h00555, 16'hBEAA, 16'h0000, 16'h0000, 1'b0, 2'b00, 16'h0000, 1'b1, 8'hAA},
        '{4'd7, 1'b0,1'b1,1'b0,1'b1,1'b1, 20'h002AA, 16'h8055, 16'h0000, 16'h0000, 1'b0, 2'b00, 16'h0000, 1'b1, 8'h55},
        // R5 write with oe high must not drive the bus
        '{4'd5, 1'b1,1'b1,1'b1,1'b1,1'b0, 20'hFFFFF, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 2'b11, 16'hFFFF, 1'b0, 8'h00},
        // R8 command while not selected does nothing
        '{4'd8, 1'b1,1'b0,1'b0,1'b1,1'b1, 20'h00007, 16'h00A0, 16'h0000, 16'h0000, 1'b0, 2'b00, 16'h0000, 1'b0, 8'h00}
    };

    task automatic check(input bit ok, input string what, input int req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: quiet while in reset
        repeat (3) @(negedge clk);
        check(dq_oe == '0, "reset dq_oe", 1, dq_oe, 0);
        check(!arr_wr, "reset arr_wr", 1, arr_wr, 0);
        check(!cmd_valid, "reset cmd_valid", 1, cmd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dq_oe == '0 && !arr_wr, "after release (R1)", 1, {dq_oe, 15'd0, arr_wr}, 0);

        for (int i = 0; i < NV; i++) begin
            word_mode = VEC[i].mode; ce = VEC[i].sel; oe = VEC[i].oen;
            we = VEC[i].wen; cmd = VEC[i].cmdn; addr = VEC[i].a; dq_in = VEC[i].dq;
            @(negedge clk);
            check(arr_addr == VEC[i].a, "arr_addr (R9)", 9, arr_addr, VEC[i].a);
            check(dq_oe == VEC[i].e_oe, "dq_oe", VEC[i].req, dq_oe, VEC[i].e_oe);
            if (VEC[i].e_oe != '0)
                check(dq_out == VEC[i].e_out, "dq_out", VEC[i].req, dq_out, VEC[i].e_out);
            check(arr_wr == VEC[i].e_wr, "arr_wr", VEC[i].req, arr_wr, VEC[i].e_wr);
            if (VEC[i].e_wr) begin
                check(arr_be == VEC[i].e_be, "arr_be", VEC[i].req, arr_be, VEC[i].e_be);
                check(arr_wdata == VEC[i].e_wd, "arr_wdata", VEC[i].req, arr_wdata, VEC[i].e_wd);
            end
            check(cmd_valid == VEC[i].e_cmdv, "cmd_valid", VEC[i].req, cmd_valid, VEC[i].e_cmdv);
            if (VEC[i].e_cmdv)
                check(cmd_data == VEC[i].e_cmdd, "cmd_data", VEC[i].req, cmd_data, VEC[i].e_cmdd);
        end

        // R1: reset applied while a write is registered clears the strobe
        word_mode = 1'b1; ce = 1'b1; oe = 1'b0; we = 1'b1; cmd = 1'b0;
        addr = 20'h00042; dq_in = 16'h4242;
        @(negedge clk);
        check(arr_wr, "write before reset (R5)", 5, arr_wr, 1);
        #1 rst_n = 1'b0;
        #1 check(!arr_wr && dq_oe == '0, "write killed by reset (R1)", 1, arr_wr, 0);
        we = 1'b0; ce = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!arr_wr && !cmd_valid, "idle after reset (R1)", 1, {arr_wr, cmd_valid}, 0);

        // R3: byte read back-to-back with lane toggling each cycle
        word_mode = 1'b0; ce = 1'b1; oe = 1'b1; addr = 20'h0ABCD; dq_in = 16'h8000;
        @(negedge clk);
        check(dq_out == 16'h000E, "lane1 streak (R3)", 3, dq_out, 16'h000E);
        dq_in = 16'h7F00;
        @(negedge clk);
        check(dq_out == 16'h000E, "lane0 streak (R3)", 3, dq_out, 16'h000E);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule